// File: doc/BRIEF.md
# Runahead Mode Controller

This controller lets an in-order pipeline keep working while the instruction at the head of the pipeline waits on a long-latency miss in the lower cache level. When that head instruction is reported as missing, the controller issues a one-cycle snapshot command for the architectural register file, records the PC of the missing instruction and switches to runahead mode. In runahead mode the instructions that follow are still executed, but only for their side effects on the memory system. Loads whose address can be computed raise prefetch requests. Any value that depends, directly or through a chain of instructions, on the missing data is tracked with a per-register poison bit. Such instructions are dropped.

In runahead mode no architectural register is written and no store reaches memory. Register results go only to a speculative copy. When the missing data returns, the controller pulses a restore command and presents the saved PC as the fetch redirect target. It clears every poison bit, and normal execution resumes at the instruction that missed. The surrounding datapath supplies one decoded instruction per cycle: its kind, its two source register indices, its destination index and its computed memory address. The datapath acts on the enables this block returns.

Top module: `runahead_ctl`

## Requirements
- R1: While reset is high and after it is released, the block is in normal mode, with snapshot, restore and prefetch outputs low and the redirect PC equal to zero.
- R2: In normal mode, when head_miss_i is high and miss_ret_i is low, ckpt_o is high in that same cycle, and ra_mode_o is high from the next cycle on. The PC on head_pc_i is captured as the redirect target.
- R3: In normal mode, a cycle with head_miss_i and miss_ret_i both high produces no snapshot pulse and no entry into runahead mode. A cycle with only miss_ret_i high has no effect either.
- R4: On entry, the poison bit of miss_dst_i is set. In runahead mode, an instruction that writes a register sets that register's poison bit when any register it reads is poisoned, and clears the bit otherwise. drop_o is high for a runahead instruction that reads a poisoned register. Kind encoding: 2'b00 ALU (reads src A and src B, writes dst), 2'b01 LOAD (address in src A, writes dst), 2'b10 STORE (address in src A), 2'b11 NOP.
- R5: In runahead mode, a valid LOAD whose address register is not poisoned raises pf_req_o in that cycle, with pf_addr_o equal to addr_i. A LOAD with a poisoned address register raises no prefetch.
- R6: mem_wr_o is high for a valid STORE in normal mode only. It is never high in runahead mode.
- R7: arch_we_o is high for a valid register-writing instruction in normal mode only. In runahead mode, spec_we_o is high for a valid register-writing instruction whose sources are not poisoned, and arch_we_o stays low.
- R8: In runahead mode, miss_ret_i causes restore_o to be high for exactly that one cycle, with redirect_pc_o equal to the PC captured at entry. The block is back in normal mode from the next cycle.
- R9: Leaving runahead mode clears every poison bit. In a later runahead episode, registers that were poisoned in the earlier episode read as valid.
- R10: head_miss_i is ignored while in runahead mode: the redirect target keeps the PC captured at entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| head_miss_i | input | 1 | Oldest instruction is waiting on a long-latency miss |
| head_pc_i | input | PC_W | PC of the oldest instruction |
| miss_dst_i | input | IDX_W | Destination register of the missing load |
| miss_ret_i | input | 1 | Data for the outstanding miss has returned |
| inst_vld_i | input | 1 | An instruction is presented this cycle |
| inst_kind_i | input | 2 | Instruction kind (encoding in R4) |
| src_a_i | input | IDX_W | Source register A (address register for loads and stores) |
| src_b_i | input | IDX_W | Source register B |
| dst_i | input | IDX_W | Destination register |
| addr_i | input | ADDR_W | Computed memory address |
| ra_mode_o | output | 1 | Runahead mode active |
| ckpt_o | output | 1 | Snapshot the architectural registers this cycle |
| restore_o | output | 1 | Restore the snapshot and redirect fetch this cycle |
| redirect_pc_o | output | PC_W | PC to resume fetching at |
| pf_req_o | output | 1 | Prefetch request |
| pf_addr_o | output | ADDR_W | Prefetch address |
| drop_o | output | 1 | Instruction dropped because a source is poisoned |
| arch_we_o | output | 1 | Architectural register write enable |
| spec_we_o | output | 1 | Speculative register copy write enable |
| mem_wr_o | output | 1 | Store write to memory enable |

## Verification
Two pairs of events can meet in one cycle. The first is a head miss and a miss return while in normal mode. The second is the exit return and a runahead instruction that still writes the speculative copy and updates the poison bits. The bench drives both on purpose. It first raises head_miss_i and miss_ret_i together in normal mode and expects no snapshot and no mode change. It then presents a poison-producing ALU instruction in the same cycle as the exit return, and expects the restore pulse, the drop for that instruction, and a clean poison state in the next episode. A behavioural reference, with the bit order, priority and encodings given in the requirements, is compared on every cycle. A stretch of random traffic follows the directed cases.

// File: rtl/ra_pkg.sv
package ra_pkg;

    typedef enum logic [1:0] {
        OP_ALU   = 2'b00,
        OP_LOAD  = 2'b01,
        OP_STORE = 2'b10,
        OP_NOP   = 2'b11
    } op_kind_e;

    typedef struct packed {
        logic writes;
        logic uses_a;
        logic uses_b;
        logic is_load;
        logic is_store;
    } op_dec_t;

    function automatic op_dec_t decode_op(input op_kind_e k);
        op_dec_t d;
        d = '0;
        unique case (k)
            OP_ALU:   begin d.writes = 1'b1; d.uses_a = 1'b1; d.uses_b = 1'b1; end
            OP_LOAD:  begin d.writes = 1'b1; d.uses_a = 1'b1; d.is_load = 1'b1; end
            OP_STORE: begin d.uses_a = 1'b1; d.is_store = 1'b1; end
            default:  d = '0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/ra_mode_fsm.sv
module ra_mode_fsm #(
    parameter int PC_W = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            head_miss,
    input  logic [PC_W-1:0] head_pc,
    input  logic            miss_ret,
    output logic            mode,
    output logic            enter,
    output logic            leave,
    output logic [PC_W-1:0] saved_pc
);
    logic            mode_q;
    logic [PC_W-1:0] pc_q;

    // A return in the same cycle as the miss cancels entry outright.
    assign enter = head_miss & ~mode_q & ~miss_ret;
    assign leave = mode_q & miss_ret;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= 1'b0;
            pc_q   <= '0;
        end else if (leave) begin
            mode_q <= 1'b0;
        end else if (enter) begin
            mode_q <= 1'b1;
            pc_q   <= head_pc;
        end
    end

    assign mode     = mode_q;
    assign saved_pc = pc_q;
endmodule

// File: rtl/ra_inv_track.sv
module ra_inv_track #(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_all,
    input  logic             set_miss,
    input  logic [IDX_W-1:0] miss_idx,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_inv,
    input  logic [IDX_W-1:0] rd_a,
    input  logic [IDX_W-1:0] rd_b,
    output logic             inv_a,
    output logic             inv_b
);
    localparam int NREG = 1 << IDX_W;

    logic [NREG-1:0] inv_vec;

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        logic flag_q;
        always_ff @(posedge clk) begin
            if (rst || clr_all) begin
                flag_q <= 1'b0;
            end else if (set_miss && miss_idx == IDX_W'(i)) begin
                flag_q <= 1'b1;
            end else if (wr_en && wr_idx == IDX_W'(i)) begin
                flag_q <= wr_inv;
            end
        end
        assign inv_vec[i] = flag_q;
    end

    assign inv_a = inv_vec[rd_a];
    assign inv_b = inv_vec[rd_b];
endmodule

// File: rtl/ra_issue.sv
module ra_issue
    import ra_pkg::*;
(
    input  logic       mode,
    input  logic       vld,
    input  logic [1:0] kind,
    input  logic       inv_a,
    input  logic       inv_b,
    output logic       pf_req,
    output logic       drop,
    output logic       arch_we,
    output logic       spec_we,
    output logic       mem_wr,
    output logic       inv_wr_en,
    output logic       inv_wr_val
);
    op_dec_t dec;
    logic    src_bad;

    always_comb begin
        dec        = decode_op(op_kind_e'(kind));
        src_bad    = (dec.uses_a & inv_a) | (dec.uses_b & inv_b);
        pf_req     = mode & vld & dec.is_load & ~src_bad;
        drop       = mode & vld & src_bad;
        arch_we    = ~mode & vld & dec.writes;
        spec_we    = mode & vld & dec.writes & ~src_bad;
        mem_wr     = ~mode & vld & dec.is_store;
        inv_wr_en  = mode & vld & dec.writes;
        inv_wr_val = src_bad;
    end
endmodule

// File: rtl/runahead_ctl.sv
module runahead_ctl #(
    parameter int PC_W   = 32,
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              head_miss_i,
    input  logic [PC_W-1:0]   head_pc_i,
    input  logic [IDX_W-1:0]  miss_dst_i,
    input  logic              miss_ret_i,
    input  logic              inst_vld_i,
    input  logic [1:0]        inst_kind_i,
    input  logic [IDX_W-1:0]  src_a_i,
    input  logic [IDX_W-1:0]  src_b_i,
    input  logic [IDX_W-1:0]  dst_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              ra_mode_o,
    output logic              ckpt_o,
    output logic              restore_o,
    output logic [PC_W-1:0]   redirect_pc_o,
    output logic              pf_req_o,
    output logic [ADDR_W-1:0] pf_addr_o,
    output logic              drop_o,
    output logic              arch_we_o,
    output logic              spec_we_o,
    output logic              mem_wr_o
);
    logic mode, enter, leave;
    logic inv_a, inv_b;
    logic inv_wr_en, inv_wr_val;

    ra_mode_fsm #(.PC_W(PC_W)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .head_miss(head_miss_i),
        .head_pc  (head_pc_i),
        .miss_ret (miss_ret_i),
        .mode     (mode),
        .enter    (enter),
        .leave    (leave),
        .saved_pc (redirect_pc_o)
    );

    ra_inv_track #(.IDX_W(IDX_W)) u_inv (
        .clk     (clk),
        .rst     (rst),
        .clr_all (leave),
        .set_miss(enter),
        .miss_idx(miss_dst_i),
        .wr_en   (inv_wr_en),
        .wr_idx  (dst_i),
        .wr_inv  (inv_wr_val),
        .rd_a    (src_a_i),
        .rd_b    (src_b_i),
        .inv_a   (inv_a),
        .inv_b   (inv_b)
    );

    ra_issue u_issue (
        .mode      (mode),
        .vld       (inst_vld_i),
        .kind      (inst_kind_i),
        .inv_a     (inv_a),
        .inv_b     (inv_b),
        .pf_req    (pf_req_o),
        .drop      (drop_o),
        .arch_we   (arch_we_o),
        .spec_we   (spec_we_o),
        .mem_wr    (mem_wr_o),
        .inv_wr_en (inv_wr_en),
        .inv_wr_val(inv_wr_val)
    );

    assign ra_mode_o = mode;
    assign ckpt_o    = enter;
    assign restore_o = leave;
    assign pf_addr_o = addr_i;
endmodule

// File: rtl/ra_checker.sv
module ra_checker #(
    parameter int PC_W = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            head_miss_i,
    input logic            miss_ret_i,
    input logic            ra_mode_o,
    input logic            ckpt_o,
    input logic            restore_o,
    input logic [PC_W-1:0] redirect_pc_o,
    input logic            pf_req_o,
    input logic            drop_o,
    input logic            arch_we_o,
    input logic            mem_wr_o
);
    a_r2_ckpt_enters: assert property (@(posedge clk) disable iff (rst)
        ckpt_o |=> ra_mode_o);

    a_r3_no_entry_on_clash: assert property (@(posedge clk) disable iff (rst)
        (head_miss_i && miss_ret_i && !ra_mode_o) |=> !ra_mode_o);

    a_r3_no_ckpt_on_clash: assert property (@(posedge clk) disable iff (rst)
        (head_miss_i && miss_ret_i) |-> !ckpt_o);

    a_r5_pf_only_clean: assert property (@(posedge clk) disable iff (rst)
        pf_req_o |-> (ra_mode_o && !drop_o));

    a_r6_no_store_in_ra: assert property (@(posedge clk) disable iff (rst)
        ra_mode_o |-> !mem_wr_o);

    a_r7_no_arch_in_ra: assert property (@(posedge clk) disable iff (rst)
        ra_mode_o |-> !arch_we_o);

    a_r8_restore_exits: assert property (@(posedge clk) disable iff (rst)
        restore_o |=> (!ra_mode_o && !restore_o));

    a_r10_pc_held: assert property (@(posedge clk) disable iff (rst)
        (ra_mode_o && $past(ra_mode_o)) |-> $stable(redirect_pc_o));
endmodule

bind runahead_ctl ra_checker #(.PC_W(PC_W)) u_ra_checker (
    .clk          (clk),
    .rst          (rst),
    .head_miss_i  (head_miss_i),
    .miss_ret_i   (miss_ret_i),
    .ra_mode_o    (ra_mode_o),
    .ckpt_o       (ckpt_o),
    .restore_o    (restore_o),
    .redirect_pc_o(redirect_pc_o),
    .pf_req_o     (pf_req_o),
    .drop_o       (drop_o),
    .arch_we_o    (arch_we_o),
    .mem_wr_o     (mem_wr_o)
);

// File: tb/runahead_ctl_bench.sv
`timescale 1ns/1ps
module runahead_ctl_bench;
    localparam int PC_W = 32, ADDR_W = 32, IDX_W = 4, NREG = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic              head_miss = 0, miss_ret = 0, vld = 0;
    logic [PC_W-1:0]   head_pc = '0;
    logic [IDX_W-1:0]  miss_dst = '0, sa = '0, sb = '0, dst = '0;
    logic [1:0]        kind = 2'b11;
    logic [ADDR_W-1:0] addr = '0;

    logic              ra_mode, ckpt, restore, pf_req, drop, arch_we, spec_we, mem_wr;
    logic [PC_W-1:0]   redir;
    logic [ADDR_W-1:0] pf_addr;

    runahead_ctl #(.PC_W(PC_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_runahead_ctl (
        .clk(clk), .rst(rst), .head_miss_i(head_miss), .head_pc_i(head_pc),
        .miss_dst_i(miss_dst), .miss_ret_i(miss_ret), .inst_vld_i(vld),
        .inst_kind_i(kind), .src_a_i(sa), .src_b_i(sb), .dst_i(dst), .addr_i(addr),
        .ra_mode_o(ra_mode), .ckpt_o(ckpt), .restore_o(restore),
        .redirect_pc_o(redir), .pf_req_o(pf_req), .pf_addr_o(pf_addr),
        .drop_o(drop), .arch_we_o(arch_we), .spec_we_o(spec_we), .mem_wr_o(mem_wr)
    );

    int    n_checks = 0, n_err = 0;
    bit    done = 0;
    string scn = "R1 reset";

    // behavioural reference state
    bit          m_mode = 0;
    logic [31:0] m_pc = '0;
    bit          m_inv [NREG];

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s [%s] actual=%0h expected=%0h t=%0t", tag, scn, act, exp, $time);
        end
    endtask

    // One cycle: inputs already set at negedge; compare, then advance the model.
    task automatic cyc();
        bit enter, leave, is_alu, is_ld, is_st, wr, bad;
        #0.5;
        enter  = !rst && head_miss && !m_mode && !miss_ret;
        leave  = !rst && m_mode && miss_ret;
        is_alu = vld && kind == 2'b00;
        is_ld  = vld && kind == 2'b01;
        is_st  = vld && kind == 2'b10;
        wr     = is_alu || is_ld;
        bad    = ((is_alu || is_ld || is_st) && m_inv[sa]) || (is_alu && m_inv[sb]);
        check("R2 mode", 32'(ra_mode), 32'(m_mode));
        check((head_miss && miss_ret) ? "R3 ckpt" : "R2 ckpt", 32'(ckpt), 32'(enter));
        check("R8 restore", 32'(restore), 32'(leave));
        check("R8/R10 redirect_pc", redir, m_pc);
        check("R5 pf_req", 32'(pf_req), 32'(m_mode && is_ld && !bad));
        if (m_mode && is_ld && !bad) check("R5 pf_addr", pf_addr, addr);
        check("R4 drop", 32'(drop), 32'(m_mode && bad));
        check("R7 arch_we", 32'(arch_we), 32'(!m_mode && wr));
        check("R7 spec_we", 32'(spec_we), 32'(m_mode && wr && !bad));
        check("R6 mem_wr", 32'(mem_wr), 32'(!m_mode && is_st));
        @(posedge clk);
        if (rst) begin
            m_mode = 0; m_pc = '0;
            foreach (m_inv[i]) m_inv[i] = 0;
        end else if (leave) begin
            m_mode = 0;
            foreach (m_inv[i]) m_inv[i] = 0;
        end else if (enter) begin
            m_mode = 1; m_pc = head_pc; m_inv[miss_dst] = 1;
        end else if (m_mode && wr) begin
            m_inv[dst] = bad;
        end
        @(negedge clk);
    endtask

    task automatic idle();
        head_miss = 0; miss_ret = 0; vld = 0; kind = 2'b11;
    endtask

    task automatic op(input logic [1:0] k, input int a, input int b, input int d, input logic [31:0] ad);
        vld = 1; kind = k; sa = IDX_W'(a); sb = IDX_W'(b); dst = IDX_W'(d); addr = ad;
        cyc();
        vld = 0; kind = 2'b11;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_err++; n_checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    initial begin : stim
        foreach (m_inv[i]) m_inv[i] = 0;
        @(negedge clk);
        scn = "R1 reset";
        repeat (3) cyc();
        rst = 0;
        cyc();

        scn = "R6/R7 normal";
        op(2'b00, 1, 2, 3, 0);
        op(2'b01, 4, 0, 5, 32'h100);
        op(2'b10, 4, 6, 0, 32'h104);
        miss_ret = 1; cyc(); idle();                 // R3 stray return

        scn = "R3 clash";
        head_miss = 1; miss_ret = 1; head_pc = 32'h40; miss_dst = 3; cyc();
        idle(); cyc();

        scn = "R2 entry";
        head_miss = 1; head_pc = 32'h80; miss_dst = 3; cyc();
        idle();
        scn = "R4 poison chain";
        op(2'b00, 3, 1, 5, 0);                       // r5 poisoned
        op(2'b00, 1, 2, 6, 0);                       // clean, spec write
        op(2'b01, 5, 0, 7, 32'h200);                 // R5 poisoned address
        op(2'b00, 7, 1, 8, 0);                       // r7 poison propagates
        scn = "R5 prefetch";
        op(2'b01, 1, 0, 9, 32'h300);
        scn = "R6 store in runahead";
        op(2'b10, 1, 2, 0, 32'h304);
        op(2'b10, 3, 2, 0, 32'h308);
        scn = "R4 overwrite clears";
        op(2'b00, 1, 2, 5, 0);
        op(2'b01, 5, 0, 10, 32'h400);
        scn = "R10 head miss ignored";
        head_miss = 1; head_pc = 32'hDEAD; miss_dst = 12; cyc(); idle();
        op(2'b01, 12, 0, 11, 32'h404);
        scn = "R8 exit with poisoned op";
        miss_ret = 1; vld = 1; kind = 2'b00; sa = 8; sb = 1; dst = 13; cyc(); idle();
        op(2'b00, 3, 5, 7, 0);                       // normal after exit
        scn = "R9 reentry";
        head_miss = 1; head_pc = 32'h1C0; miss_dst = 14; cyc(); idle();
        op(2'b01, 3, 0, 2, 32'h500);
        op(2'b01, 8, 0, 2, 32'h504);
        op(2'b00, 13, 7, 2, 0);
        op(2'b01, 14, 0, 2, 32'h508);
        miss_ret = 1; cyc(); idle(); cyc();

        scn = "random";
        for (int n = 0; n < 600; n++) begin
            head_miss = ($urandom_range(0, 7) == 0);
            miss_ret  = ($urandom_range(0, 9) == 0);
            head_pc   = $urandom;
            miss_dst  = IDX_W'($urandom_range(0, NREG-1));
            vld       = $urandom_range(0, 1);
            kind      = 2'($urandom_range(0, 3));
            sa        = IDX_W'($urandom_range(0, NREG-1));
            sb        = IDX_W'($urandom_range(0, NREG-1));
            dst       = IDX_W'($urandom_range(0, NREG-1));
            addr      = $urandom;
            cyc();
        end
        idle();
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule